// File: doc/BRIEF.md
# Serial Telemetry Line Formatter

This block turns four signed control variables into one line of plain text and sends it out of a single transmit-only UART pin. Each time a trigger is accepted it samples all four inputs at once. It then converts each one to signed decimal. The values go out in a fixed order: actual d-axis current, target d-axis current, actual q-axis current, target q-axis current. A single space separates neighbouring values, and the line ends with carriage return and line feed. A serial plotter or terminal on the far end can read each line as four numeric columns.

The conversion works one digit at a time. The block subtracts powers of ten from the magnitude, so there is no divider. Each digit is handed to the serializer as soon as it is known. The bit period is derived from a clock-frequency parameter and a baud parameter (115200 by default). There is no receive path and no flow control. A trigger that arrives while a line is still going out is simply ignored.

Top module: `telem_line_tx`

## Requirements
- R1: Every character goes out as 8N1 in this order: one start bit at 0, eight data bits with the LSB first, then one stop bit at 1. Each bit lasts round(CLK_HZ/BAUD) clock cycles.
- R2: `tx` is high from reset onward and whenever no line is in flight. It also returns high after the last stop bit of a line.
- R3: A line contains the values of `d_act`, `d_ref`, `q_act` and `q_ref`, in that order. Neighbouring values are separated by exactly one space (0x20), and the line ends with CR (0x0D) followed by LF (0x0A).
- R4: Each value is written as ASCII decimal digits (0x30 to 0x39), with the most significant digit first. Leading zeros are never printed, zeros inside a number are kept (100 prints as "100"), and a value of zero prints as a single "0".
- R5: A negative value is preceded by '-' (0x2D), and a non-negative value has no sign character. The most negative input, -32768, prints in full.
- R6: All four inputs are sampled in the cycle in which the trigger is accepted. Changes to the inputs after that cycle do not alter the line being sent.
- R7: A trigger is accepted only when no line is in progress and the serializer is idle. A trigger pulse raised while a line is in flight produces no extra line and no extra characters.
- R8: Once the stop bit of LF has finished, the next trigger starts a new line. Its start bit follows the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig | input | 1 | Request to send one line; sampled on each rising edge |
| d_act | input | VAL_W | Actual d-axis current, signed |
| d_ref | input | VAL_W | Target d-axis current, signed |
| q_act | input | VAL_W | Actual q-axis current, signed |
| q_ref | input | VAL_W | Target q-axis current, signed |
| tx | output | 1 | UART transmit line, idles high |

## Verification
The assertions check several properties on every cycle. The line stays high while the block is idle. The sampled values cannot move once a line has begun, and a line can only begin from an idle serializer while the trigger is high. A character offered to the serializer stays unchanged until it is taken. Every offered byte belongs to the allowed character set, and the digit counter never goes past nine. Other behaviours can only be shown by the bench scenarios, which decode the pin as a receiver would. These are the bit period, the exact text of each line (sign, leading-zero suppression, inner zeros, the extreme values, the separators and the terminator), the dropping of a trigger raised mid-line, and a second line following the first.

// File: rtl/telem_pkg.sv
package telem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_SIGN = 3'd2,
        ST_CALC = 3'd3,
        ST_EMIT = 3'd4,
        ST_SEP  = 3'd5,
        ST_LF   = 3'd6
    } line_st_e;

    localparam logic [7:0] CH_ZERO  = 8'h30;
    localparam logic [7:0] CH_MINUS = 8'h2D;
    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

    // Decimal digits needed for the largest magnitude of a w-bit signed value.
    function automatic int dec_digits(input int w);
        longint unsigned m;
        int n;
        m = 64'd1 << (w - 1);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            if (m != 0) begin
                m = m / 10;
                n = n + 1;
            end
        end
        return n;
    endfunction

    function automatic longint unsigned pow10(input int p);
        longint unsigned v;
        v = 1;
        for (int i = 0; i < 20; i++) begin
            if (i < p) v = v * 10;
        end
        return v;
    endfunction

endpackage

// File: rtl/telem_baud_gen.sv
module telem_baud_gen #(
    parameter int DIV = 320
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } baud_t;

    baud_t r_q, r_d;

    always_comb begin
        r_d  = r_q;
        tick = 1'b0;
        if (!run) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == LAST) begin
            tick    = 1'b1;
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/telem_uart_tx.sv
module telem_uart_tx #(
    parameter int DIV = 320
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid,
    input  logic [7:0] data,
    output logic       ready,
    output logic       tx
);
    localparam int FRAME_BITS = 10;

    typedef struct packed {
        logic       busy;
        logic [9:0] shreg;
        logic [3:0] nleft;
    } ser_t;

    ser_t r_q, r_d;
    logic tick;

    telem_baud_gen #(.DIV(DIV)) i_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (r_q.busy),
        .tick (tick)
    );

    always_comb begin
        r_d = r_q;
        if (!r_q.busy) begin
            if (valid) begin
                r_d.busy  = 1'b1;
                r_d.shreg = {1'b1, data, 1'b0};
                r_d.nleft = 4'(FRAME_BITS);
            end
        end else if (tick) begin
            r_d.shreg = {1'b1, r_q.shreg[9:1]};
            r_d.nleft = r_q.nleft - 4'd1;
            if (r_q.nleft == 4'd1) r_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ready = !r_q.busy;
    assign tx    = r_q.busy ? r_q.shreg[0] : 1'b1;

endmodule

// File: rtl/telem_line_tx.sv
module telem_line_tx
    import telem_pkg::*;
#(
    parameter int CLK_HZ = 36_864_000,
    parameter int BAUD   = 115_200,
    parameter int VAL_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig,
    input  logic signed [VAL_W-1:0] d_act,
    input  logic signed [VAL_W-1:0] d_ref,
    input  logic signed [VAL_W-1:0] q_act,
    input  logic signed [VAL_W-1:0] q_ref,
    output logic                    tx
);
    localparam int NCOL = 4;
    localparam int CW   = $clog2(NCOL);
    localparam int DIV  = (CLK_HZ + BAUD / 2) / BAUD;
    localparam int ND   = dec_digits(VAL_W);
    localparam int PW   = (ND > 1) ? $clog2(ND) : 1;
    localparam int VW1  = VAL_W + 1;

    typedef struct packed {
        line_st_e                       st;
        logic [CW-1:0]                  col;
        logic [NCOL-1:0][VAL_W-1:0]     cap;
        logic [VAL_W-1:0]               mag;
        logic [PW-1:0]                  pw;
        logic [3:0]                     dig;
        logic                           lead;
    } line_t;

    line_t r_q, r_d;

    logic [NCOL-1:0][VAL_W-1:0] in_vec;
    logic                       send_valid;
    logic [7:0]                 send_char;
    logic                       tx_rdy;
    logic [VAL_W:0]             pw_val;
    logic [VAL_W-1:0]           cur;
    logic                       show;

    // Column order on the line: index 0 is sent first.
    assign in_vec[0] = d_act;
    assign in_vec[1] = d_ref;
    assign in_vec[2] = q_act;
    assign in_vec[3] = q_ref;

    telem_uart_tx #(.DIV(DIV)) i_uart (
        .clk  (clk),
        .rst_n(rst_n),
        .valid(send_valid),
        .data (send_char),
        .ready(tx_rdy),
        .tx   (tx)
    );

    // Power of ten selected by the current digit position.
    always_comb begin
        pw_val = '0;
        for (int i = 0; i < ND; i++) begin
            if (r_q.pw == PW'(i)) pw_val = VW1'(pow10(i));
        end
    end

    assign cur  = r_q.cap[r_q.col];
    assign show = (r_q.dig != 4'd0) || r_q.lead || (r_q.pw == '0);

    always_comb begin
        r_d        = r_q;
        send_valid = 1'b0;
        send_char  = CH_ZERO;
        unique case (r_q.st)
            ST_IDLE: begin
                if (trig && tx_rdy) begin
                    r_d.cap = in_vec;
                    r_d.col = '0;
                    r_d.st  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                r_d.pw   = PW'(ND - 1);
                r_d.dig  = 4'd0;
                r_d.lead = 1'b0;
                if (cur[VAL_W-1]) begin
                    r_d.mag = ~cur + VAL_W'(1);
                    r_d.st  = ST_SIGN;
                end else begin
                    r_d.mag = cur;
                    r_d.st  = ST_CALC;
                end
            end
            ST_SIGN: begin
                send_valid = 1'b1;
                send_char  = CH_MINUS;
                if (tx_rdy) r_d.st = ST_CALC;
            end
            ST_CALC: begin
                if ({1'b0, r_q.mag} >= pw_val) begin
                    r_d.mag = r_q.mag - pw_val[VAL_W-1:0];
                    r_d.dig = r_q.dig + 4'd1;
                end else begin
                    r_d.st = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (show) begin
                    send_valid = 1'b1;
                    send_char  = CH_ZERO + {4'd0, r_q.dig};
                end
                if (!show || tx_rdy) begin
                    if (show) r_d.lead = 1'b1;
                    if (r_q.pw == '0) begin
                        r_d.st = ST_SEP;
                    end else begin
                        r_d.pw  = r_q.pw - PW'(1);
                        r_d.dig = 4'd0;
                        r_d.st  = ST_CALC;
                    end
                end
            end
            ST_SEP: begin
                send_valid = 1'b1;
                if (r_q.col == CW'(NCOL - 1)) begin
                    send_char = CH_CR;
                    if (tx_rdy) r_d.st = ST_LF;
                end else begin
                    send_char = CH_SPACE;
                    if (tx_rdy) begin
                        r_d.col = r_q.col + CW'(1);
                        r_d.st  = ST_LOAD;
                    end
                end
            end
            ST_LF: begin
                send_valid = 1'b1;
                send_char  = CH_LF;
                if (tx_rdy) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Plain views of the state for the bound checker.
    line_st_e                         st_w;
    logic [NCOL*VAL_W-1:0]            cap_w;
    logic [3:0]                       dig_w;
    assign st_w  = r_q.st;
    assign cap_w = r_q.cap;
    assign dig_w = r_q.dig;

endmodule

// File: rtl/telem_line_tx_chk.sv
module telem_line_tx_chk
    import telem_pkg::*;
#(
    parameter int CAP_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic             tx,
    input logic             tx_rdy,
    input logic             send_valid,
    input logic [7:0]       send_char,
    input line_st_e         st,
    input logic [CAP_W-1:0] cap,
    input logic [3:0]       dig
);

    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && tx_rdy) |-> tx);

    a_r6_cap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(cap));

    a_r7_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD && $past(st) == ST_IDLE) |-> ($past(tx_rdy) && $past(trig)));

    a_r4_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        dig <= 4'd9);

    a_r3_char_set: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid |-> ((send_char >= CH_ZERO && send_char <= 8'h39) ||
                        send_char == CH_MINUS || send_char == CH_SPACE ||
                        send_char == CH_CR || send_char == CH_LF));

    a_r1_char_held: assert property (@(posedge clk) disable iff (!rst_n)
        (send_valid && !tx_rdy) |=> (send_valid && $stable(send_char)));

endmodule

bind telem_line_tx telem_line_tx_chk #(.CAP_W(4 * VAL_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .tx        (tx),
    .tx_rdy    (tx_rdy),
    .send_valid(send_valid),
    .send_char (send_char),
    .st        (st_w),
    .cap       (cap_w),
    .dig       (dig_w)
);

// File: tb/test_telem_line_tx.sv
module test_telem_line_tx;
    localparam int BAUD   = 115_200;
    localparam int CLK_HZ = BAUD * 8;
    localparam int DIV    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic signed [15:0] d_act = '0, d_ref = '0, q_act = '0, q_ref = '0;
    logic        tx;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] rx_buf [0:127];
    int rx_n = 0;
    int frame_err = 0;

    always #2 clk = ~clk;

    telem_line_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .VAL_W(16)) i_telem_line_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .trig (trig),
        .d_act(d_act),
        .d_ref(d_ref),
        .q_act(q_act),
        .q_ref(q_ref),
        .tx   (tx)
    );

    // Receiver that decodes the pin as a far-end UART would.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx === 1'b0) begin
                logic [7:0] b;
                b = '0;
                repeat (DIV / 2) @(negedge clk);
                if (tx !== 1'b0) frame_err++;
                for (int i = 0; i < 8; i++) begin
                    repeat (DIV) @(negedge clk);
                    b[i] = tx;
                end
                repeat (DIV) @(negedge clk);
                if (tx !== 1'b1) frame_err++;
                if (rx_n < 128) rx_buf[rx_n] = b;
                rx_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse(input int a, input int b, input int c, input int d);
        @(negedge clk);
        d_act = 16'(a); d_ref = 16'(b); q_act = 16'(c); q_ref = 16'(d);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        for (int i = 0; i < 20000; i++) begin
            if (rx_n >= n) break;
            @(negedge clk);
        end
    endtask

    task automatic check_text(input string exp, input string req);
        int bad;
        bad = -1;
        chk(rx_n == exp.len(), req, "line length", rx_n, exp.len());
        for (int i = 0; i < exp.len(); i++) begin
            if (bad < 0 && i < rx_n && rx_buf[i] != exp[i]) bad = i;
        end
        if (bad >= 0)
            chk(1'b0, req, $sformatf("char %0d", bad), int'(rx_buf[bad]), int'(exp[bad]));
        else
            chk(1'b1, req, "line text", 0, 0);
        chk(frame_err == 0, "R1", "framing errors", frame_err, 0);
    endtask

    function automatic string fmt_line(input int a, input int b, input int c, input int d);
        return $sformatf("%0d %0d %0d %0d\r\n", a, b, c, d);
    endfunction

    task automatic t_reset();
        int hi_bad;
        hi_bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (tx !== 1'b1) hi_bad++;
        end
        chk(hi_bad == 0, "R2", "tx low cycles after reset", hi_bad, 0);
        chk(rx_n == 0, "R2", "chars after reset", rx_n, 0);
    endtask

    task automatic t_line(input int a, input int b, input int c, input int d, input string req);
        string e;
        e = fmt_line(a, b, c, d);
        rx_n = 0;
        pulse(a, b, c, d);
        wait_rx(e.len());
        repeat (2 * DIV) @(negedge clk);
        check_text(e, req);
        chk(tx === 1'b1, "R2", "tx after line", int'(tx), 1);
    endtask

    // R1: first char '-' has bit0 = 1, so the start bit alone is low.
    task automatic t_bit_time();
        int low;
        string e;
        e = fmt_line(-1, 2, 3, 4);
        rx_n = 0;
        low = 0;
        pulse(-1, 2, 3, 4);
        for (int i = 0; i < 1000; i++) begin
            if (tx === 1'b0) break;
            @(negedge clk);
        end
        while (tx === 1'b0 && low < 1000) begin
            low++;
            @(negedge clk);
        end
        chk(low == DIV, "R1", "start bit cycles", low, DIV);
        wait_rx(e.len());
        repeat (2 * DIV) @(negedge clk);
        check_text(e, "R1");
    endtask

    task automatic t_capture();
        string e;
        e = fmt_line(11, -22, 33, -44);
        rx_n = 0;
        pulse(11, -22, 33, -44);
        d_act = 16'sd999; d_ref = -16'sd999; q_act = 16'sd7; q_ref = 16'sd8;
        repeat (40) @(negedge clk);
        d_act = 16'sd1;
        wait_rx(e.len());
        repeat (2 * DIV) @(negedge clk);
        check_text(e, "R6");
    endtask

    task automatic t_drop();
        string e;
        e = fmt_line(1, 2, 3, 4);
        rx_n = 0;
        pulse(1, 2, 3, 4);
        repeat (100) @(negedge clk);
        pulse(5, 6, 7, 8);
        wait_rx(e.len());
        pulse(9, 9, 9, 9);
        repeat (40 * DIV * 10) @(negedge clk);
        check_text(e, "R7");
        chk(tx === 1'b1, "R7", "tx idle after dropped triggers", int'(tx), 1);
    endtask

    task automatic t_back_to_back();
        string e;
        string e1;
        e1 = fmt_line(-5, 50, -500, 5000);
        e = {e1, fmt_line(7, -70, 700, -7000)};
        rx_n = 0;
        pulse(-5, 50, -500, 5000);
        wait_rx(e1.len());
        repeat (DIV) @(negedge clk);
        pulse(7, -70, 700, -7000);
        wait_rx(e.len());
        repeat (2 * DIV) @(negedge clk);
        check_text(e, "R8");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bit_time();
        t_line(200, -200, 37, -4, "R3");
        t_line(100, 1000, 9, 10, "R4");
        t_line(0, 0, 0, 0, "R4");
        t_line(-32768, 32767, -10, 1, "R5");
        t_capture();
        t_drop();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule